// File: doc/BRIEF.md
# Excess-Bias Interpolating Estimator and Pump Code Servo

This block closes the digital part of a bias-regulation loop for an avalanche photodiode array. Each update request brings one measured operating point: an averaged avalanche pulse width and a dark count rate. With it comes the calibration neighbourhood around the present operating point: the grid origin, and two step vectors. One step vector runs along the bias axis of the grid and the other along the temperature axis. The block expresses the measured offset from the origin as a weighted sum of the two step vectors. It solves the resulting 2x2 linear system with one shared determinant and a sequential signed divider.

The two weights, in fixed point, give the estimated bias and the estimated temperature as the grid values plus the weighted grid steps. The estimated bias is then compared with a target, and the 5-bit charge-pump code is moved by at most one step toward it. The deadband is half a pump step, so a step that would overshoot is not taken. The 6-bit oscillator code that comes with the request is applied on the same edge, so both codes always change together. If the determinant is zero the step vectors are collinear. In that case the block raises an error pulse and leaves every result unchanged.

Top module: `xbias_servo`

## Requirements
- R1: After synchronous reset the pump code is 16, the oscillator code is 32, both weights and both estimates are 0, and busy, done and error are low.
- R2: A start pulse is taken only while busy is low. The request inputs are captured on that edge and busy is high from the next cycle until the result or error cycle. Start pulses and input changes while busy have no effect.
- R3: With x = measured − origin, and with the bias step a and the temperature step b, det = PWa·DCRb − PWb·DCRa. The bias weight is (DCRb·PWx − PWb·DCRx)·256/det and the temperature weight is (PWa·DCRx − DCRa·PWx)·256/det. Both are truncated toward zero and carry 8 fraction bits.
- R4: The bias estimate is grid_bias + floor(weight_a·bias_step/256) and the temperature estimate is grid_temp + floor(weight_b·temp_step/256). Each keeps the low 16 bits as a signed value.
- R5: For a nonzero determinant, done is a one-cycle pulse on the 71st clock edge after the start edge, where 71 = 2·(2·IW+2+FRAC)+3. Weights, estimates and codes update on that same edge.
- R6: For a zero determinant, the error pulse is high for one cycle after the 3rd edge counted from the start edge (the start edge is the first). Weights, estimates and both codes keep their previous values, and no done pulse follows.
- R7: On a done edge the pump code is incremented if the new bias estimate is more than 40 below the target, and decremented if it is more than 40 above. Otherwise it holds. A difference of exactly ±40 holds, and the code saturates at 31 and at 0.
- R8: On a done edge the oscillator code takes the oscillator request captured at start. It changes on no other edge.
- R9: Done and error are never high together, and busy is low in any cycle where either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Update request, taken while idle |
| meas_pw_i | input | IW (12) | Measured averaged pulse width, unsigned |
| meas_dcr_i | input | IW (12) | Measured dark count rate, unsigned |
| org_pw_i | input | IW (12) | Grid origin pulse width, unsigned |
| org_dcr_i | input | IW (12) | Grid origin count rate, unsigned |
| bstep_pw_i | input | IW (12) | Bias-axis step, pulse-width part, signed |
| bstep_dcr_i | input | IW (12) | Bias-axis step, count-rate part, signed |
| tstep_pw_i | input | IW (12) | Temperature-axis step, pulse-width part, signed |
| tstep_dcr_i | input | IW (12) | Temperature-axis step, count-rate part, signed |
| grid_bias_i | input | EW (16) | Bias at grid origin (mV), signed |
| grid_temp_i | input | EW (16) | Temperature at grid origin, signed |
| bias_inc_i | input | EW (16) | Grid bias spacing (mV), signed |
| temp_inc_i | input | EW (16) | Grid temperature spacing, signed |
| target_bias_i | input | EW (16) | Target bias (mV), signed |
| osc_req_i | input | OW (6) | Oscillator code to apply with the result |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | One-cycle singular-determinant pulse |
| alpha_o | output | QW (35) | Bias weight, signed, 8 fraction bits |
| beta_o | output | QW (35) | Temperature weight, signed, 8 fraction bits |
| bias_est_o | output | EW (16) | Estimated bias, signed |
| temp_est_o | output | EW (16) | Estimated temperature, signed |
| pump_code_o | output | CW (5) | Charge-pump control code |
| osc_code_o | output | OW (6) | Oscillator control code |

## Verification
The two events that can share a cycle are a new start request and the result cycle of the request in progress. A start sampled on the result edge must be ignored, and a start on the very next edge must be accepted with the inputs present then. The bench drives start high across exactly those two edges, and it also changes the inputs in the middle of a run. A behavioural model that latches only accepted requests is compared with every output on every clock, so any wrong acceptance shows as a busy, done or value miscompare.

// File: rtl/xbias_pkg.sv
package xbias_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROD,
        ST_CHK,
        ST_DIV,
        ST_APPLY
    } xb_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_UP,
        STEP_DOWN
    } step_e;

    // Direction of the pump move for a bias error (estimate minus target).
    function automatic step_e pick_step(input longint diff, input longint half);
        if (diff < -half)
            return STEP_UP;
        else if (diff > half)
            return STEP_DOWN;
        else
            return STEP_HOLD;
    endfunction

    // Saturating one-step move of a code inside [0, cmax].
    function automatic int code_next(input int code, input step_e s, input int cmax);
        case (s)
            STEP_UP:   return (code >= cmax) ? cmax : code + 1;
            STEP_DOWN: return (code <= 0) ? 0 : code - 1;
            default:   return code;
        endcase
    endfunction

endpackage

// File: rtl/xbias_cross.sv
// Cross products of the 2x2 system: shared determinant and both numerators.
module xbias_cross #(
    parameter int IW  = 12,
    parameter int XW  = IW + 1,
    parameter int PRW = 2 * IW + 2
) (
    input  logic signed [XW-1:0]  x_pw_i,
    input  logic signed [XW-1:0]  x_dcr_i,
    input  logic signed [IW-1:0]  a_pw_i,
    input  logic signed [IW-1:0]  a_dcr_i,
    input  logic signed [IW-1:0]  b_pw_i,
    input  logic signed [IW-1:0]  b_dcr_i,
    output logic signed [PRW-1:0] det_o,
    output logic signed [PRW-1:0] num_a_o,
    output logic signed [PRW-1:0] num_b_o
);

    always_comb begin
        det_o   = (PRW'(a_pw_i) * PRW'(b_dcr_i)) - (PRW'(b_pw_i) * PRW'(a_dcr_i));
        num_a_o = (PRW'(b_dcr_i) * PRW'(x_pw_i)) - (PRW'(b_pw_i) * PRW'(x_dcr_i));
        num_b_o = (PRW'(a_pw_i) * PRW'(x_dcr_i)) - (PRW'(a_dcr_i) * PRW'(x_pw_i));
    end

endmodule

// File: rtl/xbias_sdiv.sv
// Restoring signed divider: quotient = trunc(num * 2^FRAC / den), one bit per cycle.
module xbias_sdiv #(
    parameter int NW   = 26,
    parameter int FRAC = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_i,
    input  logic signed [NW-1:0]          num_i,
    input  logic signed [NW-1:0]          den_i,
    output logic                          fin_o,
    output logic signed [NW+FRAC:0]       quo_o
);

    localparam int DVW  = NW + FRAC;
    localparam int CNTW = $clog2(DVW + 1);

    logic [DVW-1:0]  dvd_q;
    logic [DVW-1:0]  quo_q;
    logic [NW-1:0]   rem_q;
    logic [NW-1:0]   dsr_q;
    logic [CNTW-1:0] cnt_q;
    logic            run_q;
    logic            neg_q;

    logic [NW-1:0]   num_mag;
    logic [NW-1:0]   den_mag;
    logic [NW:0]     rem_sh;
    logic            ge;
    logic [NW-1:0]   rem_nx;
    logic [DVW-1:0]  quo_nx;

    always_comb begin
        num_mag = num_i[NW-1] ? NW'(-num_i) : NW'(num_i);
        den_mag = den_i[NW-1] ? NW'(-den_i) : NW'(den_i);
        rem_sh  = {rem_q, dvd_q[DVW-1]};
        ge      = (rem_sh >= {1'b0, dsr_q});
        rem_nx  = ge ? (rem_sh[NW-1:0] - dsr_q) : rem_sh[NW-1:0];
        quo_nx  = {quo_q[DVW-2:0], ge};
        fin_o   = run_q && (cnt_q == CNTW'(1));
        quo_o   = neg_q ? -$signed({1'b0, quo_nx}) : $signed({1'b0, quo_nx});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            neg_q <= 1'b0;
        end else if (load_i) begin
            dvd_q <= {num_mag, {FRAC{1'b0}}};
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= den_mag;
            cnt_q <= CNTW'(DVW);
            run_q <= 1'b1;
            neg_q <= num_i[NW-1] ^ den_i[NW-1];
        end else if (run_q) begin
            dvd_q <= dvd_q << 1;
            quo_q <= quo_nx;
            rem_q <= rem_nx;
            cnt_q <= cnt_q - CNTW'(1);
            if (cnt_q == CNTW'(1))
                run_q <= 1'b0;
        end
    end

endmodule

// File: rtl/xbias_project.sv
// Grid value plus fixed-point weight times grid spacing (floor of the product).
module xbias_project #(
    parameter int QW   = 35,
    parameter int EW   = 16,
    parameter int FRAC = 8
) (
    input  logic signed [QW-1:0] wt_i,
    input  logic signed [EW-1:0] inc_i,
    input  logic signed [EW-1:0] base_i,
    output logic signed [EW-1:0] est_o
);

    localparam int PW = QW + EW;

    logic signed [PW-1:0] prod;

    always_comb begin
        prod  = PW'(wt_i) * PW'(inc_i);
        est_o = base_i + EW'(prod >>> FRAC);
    end

endmodule

// File: rtl/xbias_code_step.sv
// Pump code move with half-step deadband and saturation.
module xbias_code_step
    import xbias_pkg::*;
#(
    parameter int EW   = 16,
    parameter int CW   = 5,
    parameter int HALF = 40
) (
    input  logic signed [EW-1:0] est_i,
    input  logic signed [EW-1:0] target_i,
    input  logic [CW-1:0]        code_i,
    output logic [CW-1:0]        code_o
);

    localparam int CMAX = (1 << CW) - 1;

    logic signed [EW:0] diff;
    step_e              dir;

    always_comb begin
        diff   = (EW+1)'(est_i) - (EW+1)'(target_i);
        dir    = pick_step(longint'(diff), longint'(HALF));
        code_o = CW'(code_next(int'(code_i), dir, CMAX));
    end

endmodule

// File: rtl/xbias_servo.sv
module xbias_servo
    import xbias_pkg::*;
#(
    parameter int IW        = 12,
    parameter int FRAC      = 8,
    parameter int EW        = 16,
    parameter int CW        = 5,
    parameter int OW        = 6,
    parameter int PUMP_INIT = 16,
    parameter int OSC_INIT  = 32,
    parameter int HALF_STEP = 40,
    parameter int QW        = 2 * IW + 2 + FRAC + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [IW-1:0]        meas_pw_i,
    input  logic [IW-1:0]        meas_dcr_i,
    input  logic [IW-1:0]        org_pw_i,
    input  logic [IW-1:0]        org_dcr_i,
    input  logic signed [IW-1:0] bstep_pw_i,
    input  logic signed [IW-1:0] bstep_dcr_i,
    input  logic signed [IW-1:0] tstep_pw_i,
    input  logic signed [IW-1:0] tstep_dcr_i,
    input  logic signed [EW-1:0] grid_bias_i,
    input  logic signed [EW-1:0] grid_temp_i,
    input  logic signed [EW-1:0] bias_inc_i,
    input  logic signed [EW-1:0] temp_inc_i,
    input  logic signed [EW-1:0] target_bias_i,
    input  logic [OW-1:0]        osc_req_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic signed [QW-1:0] alpha_o,
    output logic signed [QW-1:0] beta_o,
    output logic signed [EW-1:0] bias_est_o,
    output logic signed [EW-1:0] temp_est_o,
    output logic [CW-1:0]        pump_code_o,
    output logic [OW-1:0]        osc_code_o
);

    localparam int XW  = IW + 1;
    localparam int PRW = 2 * IW + 2;
    localparam int NAX = 2;

    typedef struct packed {
        logic signed [XW-1:0] x_pw;
        logic signed [XW-1:0] x_dcr;
        logic signed [IW-1:0] a_pw;
        logic signed [IW-1:0] a_dcr;
        logic signed [IW-1:0] b_pw;
        logic signed [IW-1:0] b_dcr;
        logic signed [EW-1:0] g_bias;
        logic signed [EW-1:0] g_temp;
        logic signed [EW-1:0] inc_bias;
        logic signed [EW-1:0] inc_temp;
        logic signed [EW-1:0] target;
        logic [OW-1:0]        osc;
    } req_t;

    xb_state_e            state_q;
    req_t                 req_q;
    logic signed [PRW-1:0] det_q, na_q, nb_q;
    logic signed [PRW-1:0] det_c, na_c, nb_c;
    logic                 sel_q;
    logic signed [QW-1:0] alpha_h, beta_h;

    logic                 div_load;
    logic signed [PRW-1:0] div_num;
    logic                 div_fin;
    logic signed [QW-1:0] div_quo;

    logic signed [QW-1:0] wt   [NAX];
    logic signed [EW-1:0] incs [NAX];
    logic signed [EW-1:0] base [NAX];
    logic signed [EW-1:0] est  [NAX];
    logic [CW-1:0]        pump_nx;

    xbias_cross #(.IW(IW), .XW(XW), .PRW(PRW)) u_cross (
        .x_pw_i  (req_q.x_pw),
        .x_dcr_i (req_q.x_dcr),
        .a_pw_i  (req_q.a_pw),
        .a_dcr_i (req_q.a_dcr),
        .b_pw_i  (req_q.b_pw),
        .b_dcr_i (req_q.b_dcr),
        .det_o   (det_c),
        .num_a_o (na_c),
        .num_b_o (nb_c)
    );

    always_comb begin
        div_load = ((state_q == ST_CHK) && (det_q != '0)) ||
                   ((state_q == ST_DIV) && div_fin && !sel_q);
        div_num  = (state_q == ST_CHK) ? na_q : nb_q;
    end

    xbias_sdiv #(.NW(PRW), .FRAC(FRAC)) u_div (
        .clk    (clk),
        .rst    (rst),
        .load_i (div_load),
        .num_i  (div_num),
        .den_i  (det_q),
        .fin_o  (div_fin),
        .quo_o  (div_quo)
    );

    always_comb begin
        wt[0]   = alpha_h;
        wt[1]   = beta_h;
        incs[0] = req_q.inc_bias;
        incs[1] = req_q.inc_temp;
        base[0] = req_q.g_bias;
        base[1] = req_q.g_temp;
    end

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        xbias_project #(.QW(QW), .EW(EW), .FRAC(FRAC)) u_prj (
            .wt_i   (wt[g]),
            .inc_i  (incs[g]),
            .base_i (base[g]),
            .est_o  (est[g])
        );
    end

    xbias_code_step #(.EW(EW), .CW(CW), .HALF(HALF_STEP)) u_step (
        .est_i    (est[0]),
        .target_i (req_q.target),
        .code_i   (pump_code_o),
        .code_o   (pump_nx)
    );

    assign busy_o = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            req_q       <= '0;
            det_q       <= '0;
            na_q        <= '0;
            nb_q        <= '0;
            sel_q       <= 1'b0;
            alpha_h     <= '0;
            beta_h      <= '0;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
            alpha_o     <= '0;
            beta_o      <= '0;
            bias_est_o  <= '0;
            temp_est_o  <= '0;
            pump_code_o <= CW'(PUMP_INIT);
            osc_code_o  <= OW'(OSC_INIT);
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q.x_pw     <= $signed({1'b0, meas_pw_i}) - $signed({1'b0, org_pw_i});
                        req_q.x_dcr    <= $signed({1'b0, meas_dcr_i}) - $signed({1'b0, org_dcr_i});
                        req_q.a_pw     <= bstep_pw_i;
                        req_q.a_dcr    <= bstep_dcr_i;
                        req_q.b_pw     <= tstep_pw_i;
                        req_q.b_dcr    <= tstep_dcr_i;
                        req_q.g_bias   <= grid_bias_i;
                        req_q.g_temp   <= grid_temp_i;
                        req_q.inc_bias <= bias_inc_i;
                        req_q.inc_temp <= temp_inc_i;
                        req_q.target   <= target_bias_i;
                        req_q.osc      <= osc_req_i;
                        state_q        <= ST_PROD;
                    end
                end
                ST_PROD: begin
                    det_q   <= det_c;
                    na_q    <= na_c;
                    nb_q    <= nb_c;
                    state_q <= ST_CHK;
                end
                ST_CHK: begin
                    sel_q <= 1'b0;
                    if (det_q == '0) begin
                        err_o   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        if (!sel_q) begin
                            alpha_h <= div_quo;
                            sel_q   <= 1'b1;
                        end else begin
                            beta_h  <= div_quo;
                            state_q <= ST_APPLY;
                        end
                    end
                end
                ST_APPLY: begin
                    alpha_o     <= alpha_h;
                    beta_o      <= beta_h;
                    bias_est_o  <= est[0];
                    temp_est_o  <= est[1];
                    pump_code_o <= pump_nx;
                    osc_code_o  <= req_q.osc;
                    done_o      <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xbias_servo_chk.sv
module xbias_servo_chk #(
    parameter int EW = 16,
    parameter int CW = 5,
    parameter int OW = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic                 err_o,
    input logic signed [EW-1:0] bias_est_o,
    input logic signed [EW-1:0] temp_est_o,
    input logic [CW-1:0]        pump_code_o,
    input logic [OW-1:0]        osc_code_o
);

    a_r9_done_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    a_r9_idle_on_result: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o) |-> !busy_o);

    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    a_r7_pump_moves_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(pump_code_o) |-> done_o);

    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((int'(pump_code_o) - int'($past(pump_code_o)) <= 1) &&
                    (int'(pump_code_o) - int'($past(pump_code_o)) >= -1)));

    a_r8_osc_moves_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(osc_code_o) |-> done_o);

    a_r6_err_keeps_results: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($stable(bias_est_o) && $stable(temp_est_o) && $stable(pump_code_o)));

endmodule

bind xbias_servo xbias_servo_chk #(.EW(EW), .CW(CW), .OW(OW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .bias_est_o  (bias_est_o),
    .temp_est_o  (temp_est_o),
    .pump_code_o (pump_code_o),
    .osc_code_o  (osc_code_o)
);

// File: tb/xbias_servo_tb_top.sv
module xbias_servo_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IW   = 12;
    localparam int FRAC = 8;
    localparam int EW   = 16;
    localparam int CW   = 5;
    localparam int OW   = 6;
    localparam int QW   = 2 * IW + 2 + FRAC + 1;
    localparam int LAT  = 2 * (2 * IW + 2 + FRAC) + 3;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [IW-1:0] meas_pw = '0, meas_dcr = '0, org_pw = '0, org_dcr = '0;
    logic signed [IW-1:0] apw = '0, adcr = '0, bpw = '0, bdcr = '0;
    logic signed [EW-1:0] gbias = '0, gtemp = '0, dve = '0, dtt = '0, tgt = '0;
    logic [OW-1:0] oreq = '0;

    logic busy, done, err;
    logic signed [QW-1:0] alpha, beta;
    logic signed [EW-1:0] bias_est, temp_est;
    logic [CW-1:0] pump;
    logic [OW-1:0] osc;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbias_servo dut_i (
        .clk(clk), .rst(rst), .start_i(start),
        .meas_pw_i(meas_pw), .meas_dcr_i(meas_dcr),
        .org_pw_i(org_pw), .org_dcr_i(org_dcr),
        .bstep_pw_i(apw), .bstep_dcr_i(adcr),
        .tstep_pw_i(bpw), .tstep_dcr_i(bdcr),
        .grid_bias_i(gbias), .grid_temp_i(gtemp),
        .bias_inc_i(dve), .temp_inc_i(dtt),
        .target_bias_i(tgt), .osc_req_i(oreq),
        .busy_o(busy), .done_o(done), .err_o(err),
        .alpha_o(alpha), .beta_o(beta),
        .bias_est_o(bias_est), .temp_est_o(temp_est),
        .pump_code_o(pump), .osc_code_o(osc)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit seen_edge = 0;
    bit ended = 0;

    // reference model state
    int     m_busy, m_cnt, m_done, m_err, m_pump, m_osc;
    longint m_alpha, m_beta, m_bias, m_temp;
    int     p_zero, p_osc;
    longint p_alpha, p_beta, p_bias, p_temp, p_tgt;

    function automatic longint wrap16(input longint v);
        logic signed [15:0] t;
        t = v[15:0];
        return longint'(t);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_done = 0; m_err = 0;
            m_pump = 16; m_osc = 32;
            m_alpha = 0; m_beta = 0; m_bias = 0; m_temp = 0;
        end else begin
            m_done = 0; m_err = 0;
            if (m_busy == 0) begin
                if (start) begin
                    longint xp, xd, dt, na, nb;
                    xp = longint'(meas_pw) - longint'(org_pw);
                    xd = longint'(meas_dcr) - longint'(org_dcr);
                    dt = longint'(apw) * longint'(bdcr) - longint'(bpw) * longint'(adcr);
                    na = longint'(bdcr) * xp - longint'(bpw) * xd;
                    nb = longint'(apw) * xd - longint'(adcr) * xp;
                    p_zero = (dt == 0);
                    if (!p_zero) begin
                        p_alpha = (na * 256) / dt;
                        p_beta  = (nb * 256) / dt;
                        p_bias  = wrap16(longint'(gbias) + ((p_alpha * longint'(dve)) >>> FRAC));
                        p_temp  = wrap16(longint'(gtemp) + ((p_beta * longint'(dtt)) >>> FRAC));
                    end
                    p_tgt = longint'(tgt);
                    p_osc = int'(oreq);
                    m_busy = 1;
                    m_cnt = p_zero ? 2 : LAT;
                end
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    if (p_zero) m_err = 1;
                    else begin
                        m_alpha = p_alpha; m_beta = p_beta;
                        m_bias = p_bias; m_temp = p_temp;
                        if (p_bias - p_tgt < -40) m_pump = (m_pump >= 31) ? 31 : m_pump + 1;
                        else if (p_bias - p_tgt > 40) m_pump = (m_pump <= 0) ? 0 : m_pump - 1;
                        m_osc = p_osc;
                        m_done = 1;
                    end
                end
            end
        end
        seen_edge = 1;
        cyc++;
    end

    task automatic chk(input string tag, input string nm, input longint got, input longint exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, nm, cyc, got, exp);
        end
    endtask

    function automatic string tg(input string r);
        return rst ? "R1" : r;
    endfunction

    always @(negedge clk) begin
        if (seen_edge && !ended) begin
            chk(tg("R2"), "busy", longint'(busy), longint'(m_busy));
            chk(tg("R5"), "done", longint'(done), longint'(m_done));
            chk(tg("R6"), "err", longint'(err), longint'(m_err));
            chk(tg("R3"), "alpha", longint'(alpha), m_alpha);
            chk(tg("R3"), "beta", longint'(beta), m_beta);
            chk(tg("R4"), "bias_est", longint'(bias_est), m_bias);
            chk(tg("R4"), "temp_est", longint'(temp_est), m_temp);
            chk(tg("R7"), "pump_code", longint'(pump), longint'(m_pump));
            chk(tg("R8"), "osc_code", longint'(osc), longint'(m_osc));
            chk(tg("R9"), "done_err_excl", longint'(done && err), 0);
            if (cyc > WDOG) begin
                n_bad++;
                $display("FAIL R5 watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
                finish_run();
            end
        end
    end

    task automatic finish_run();
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic set_req(input int mp, input int md, input int op, input int od,
                           input int ap, input int ad, input int bp, input int bd,
                           input int gb, input int gt, input int ve, input int tt,
                           input int tg_v, input int o);
        meas_pw = IW'(mp); meas_dcr = IW'(md); org_pw = IW'(op); org_dcr = IW'(od);
        apw = IW'(ap); adcr = IW'(ad); bpw = IW'(bp); bdcr = IW'(bd);
        gbias = EW'(gb); gtemp = EW'(gt); dve = EW'(ve); dtt = EW'(tt);
        tgt = EW'(tg_v); oreq = OW'(o);
    endtask

    task automatic go();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT + 1) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3 R4 R7: positive weights, estimate far below target, climb to saturation at 31
        for (int i = 0; i < 17; i++) begin
            set_req(330, 140, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 3000, i);
            go();
        end
        // R3 R4 R7: negative weights, estimate far above target, descend to saturation at 0
        for (int i = 0; i < 33; i++) begin
            set_req(270, 60, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 1500, 63 - i);
            go();
        end
        // R7 deadband boundaries around estimate 2796
        set_req(330, 140, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 2837, 1); go();
        set_req(330, 140, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 2836, 2); go();
        set_req(330, 140, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 2756, 3); go();
        set_req(330, 140, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 2755, 4); go();
        set_req(330, 140, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 2830, 5); go();
        // R6: collinear steps give a zero determinant; results must hold
        set_req(350, 150, 300, 100, 20, 10, 40, 20, 1000, 0, 500, 100, 3000, 9); go();
        // R2: start and input changes in the middle of a run are ignored
        set_req(330, 140, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 3000, 11);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        set_req(100, 900, 300, 100, 33, -7, 12, 50, -200, 50, 500, 100, -900, 40);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT) @(negedge clk);
        // R2 R5: start held across the result edge (ignored) and the next edge (accepted)
        set_req(330, 140, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 1000, 12);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        set_req(310, 90, 300, 100, 40, 5, 10, 60, 2500, 300, 500, 100, 4000, 13);
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (LAT + 1) @(negedge clk);
        // random operating points
        for (int i = 0; i < 60; i++) begin
            set_req(int'($urandom_range(0, 4095)), int'($urandom_range(0, 4095)),
                    int'($urandom_range(0, 4095)), int'($urandom_range(0, 4095)),
                    int'($urandom_range(0, 400)) - 200, int'($urandom_range(0, 400)) - 200,
                    int'($urandom_range(0, 400)) - 200, int'($urandom_range(0, 400)) - 200,
                    int'($urandom_range(0, 4000)), int'($urandom_range(0, 700)),
                    int'($urandom_range(100, 600)), int'($urandom_range(50, 150)),
                    int'($urandom_range(0, 4000)), int'($urandom_range(0, 63)));
            if (i % 7 == 3) begin
                bpw = apw * 2; bdcr = adcr * 2;
            end
            go();
        end
        finish_run();
    end

endmodule